// File: doc/BRIEF.md
# Pipelined Packed-Halfword Multiplier

This unit multiplies one 16-bit half of a 32-bit word by one 16-bit half of another 32-bit word and produces a 32-bit product. A separate select bit for each operand chooses which half is used, so the caller can multiply packed pairs of 16-bit values without unpacking them first. A two-bit mode input sets how the halves are read. They can both be signed, the first signed and the second unsigned, or both unsigned. A fourth mode gives a signed fractional product, which is the signed product shifted left by one place.

The unit has two register stages and no stall input. It takes a new operation on every cycle, and the result comes out exactly two cycles after it was issued, tagged with a valid bit. A fractional multiply of the most negative value by itself cannot be represented. In that case the unit saturates the result to the largest positive 32-bit value and raises a saturation pulse alongside the result. It also sets a sticky flag, which stays high until it is explicitly cleared.

Top module: `hmul_top`

## Requirements
- R1: Each operand's half-select bit picks that operand's bits [31:16] when 1 and its bits [15:0] when 0. The two select bits act independently of each other.
- R2: Mode 0 (`2'b00`) treats both selected halves as two's-complement signed numbers. The result is their full 32-bit product.
- R3: Mode 1 (`2'b01`) treats the first operand's half as signed and the second operand's half as unsigned. The result is the low 32 bits of their product.
- R4: Mode 2 (`2'b10`) treats both halves as unsigned. The result is their full 32-bit product.
- R5: `outValid` equals `inValid` delayed by exactly two clock cycles. An operation issued on every cycle gives one result on every cycle, in issue order.
- R6: Mode 3 (`2'b11`) treats both halves as signed and returns the signed product shifted left by one bit. Bit 0 of an unsaturated fractional result is therefore always 0.
- R7: In mode 3, when both selected halves are `16'h8000`, the result is `32'h7FFFFFFF` and `outSat` is high in the same cycle as `outValid`. In every other case `outSat` is low.
- R8: `satSticky` goes high on the same cycle as `outSat`. It stays high until a cycle in which `satClear` is high and no new saturation arrives. If a saturation and a clear occur together, the flag stays set.
- R9: After reset, `outValid`, `outSat`, `satSticky` and `outResult` are all 0.
- R10: An operation presented with `inValid` low has no effect. It produces no `outValid`, no `outSat` and no change to `satSticky`, and `outResult` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| inMode | input | 2 | 0 signed×signed, 1 signed×unsigned, 2 unsigned×unsigned, 3 signed fractional |
| inHiA | input | 1 | First operand uses upper half when 1 |
| inHiB | input | 1 | Second operand uses upper half when 1 |
| inA | input | 32 | First operand word |
| inB | input | 32 | Second operand word |
| satClear | input | 1 | Clears the sticky saturation flag |
| outValid | output | 1 | Result valid, two cycles after issue |
| outResult | output | 32 | Product |
| outSat | output | 1 | This result was saturated |
| satSticky | output | 1 | Sticky saturation flag |

## Verification
Each internal stage shows up at the ports exactly two cycles after issue. A wrong sign extension or a wrong half selection in the first stage therefore appears as a wrong `outResult` on the second cycle. Back-to-back operations with different modes make sure stage-one mode bits are not mixed up between neighbouring operations. A broken valid pipeline appears at once as a missing or extra `outValid`. A fault in the sticky logic appears on the cycle after a saturation or a clear. The bench checks the set-and-clear collision on that same cycle.

// File: rtl/hmul_pkg.sv
package hmul_pkg;
  typedef enum logic [1:0] {
    MODE_SS   = 2'b00,
    MODE_SU   = 2'b01,
    MODE_UU   = 2'b10,
    MODE_FRAC = 2'b11
  } hmulMode_e;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
    logic signA;
    logic signB;
    logic frac;
  } hmulStrobes_t;
endpackage

// File: rtl/hmul_ctrl.sv
module hmul_ctrl
  import hmul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   inMode,
  input  logic         satClear,
  input  logic         satDetect,
  output hmulStrobes_t strobes,
  output logic         outValid,
  output logic         satSticky
);
  logic validS1;
  hmulMode_e mode;

  assign mode = hmulMode_e'(inMode);

  always_comb begin
    strobes.s1Load = inValid;
    strobes.s2Load = validS1;
    strobes.signA  = (mode != MODE_UU);
    strobes.signB  = (mode == MODE_SS) || (mode == MODE_FRAC);
    strobes.frac   = (mode == MODE_FRAC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validS1   <= 1'b0;
      outValid  <= 1'b0;
      satSticky <= 1'b0;
    end else begin
      validS1   <= inValid;
      outValid  <= validS1;
      satSticky <= (satSticky & ~satClear) | satDetect;
    end
  end
endmodule

// File: rtl/hmul_datapath.sv
module hmul_datapath
  import hmul_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hmulStrobes_t          strobes,
  input  logic                  inHiA,
  input  logic                  inHiB,
  input  logic [2*HALF_W-1:0]   inA,
  input  logic [2*HALF_W-1:0]   inB,
  output logic                  satDetect,
  output logic [2*HALF_W-1:0]   outResult,
  output logic                  outSat
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int EXT_W  = HALF_W + 1;
  localparam int PROD_W = 2 * EXT_W;

  logic [WORD_W-1:0]       opWord [2];
  logic                    opHi   [2];
  logic                    opSign [2];
  logic signed [EXT_W-1:0] opExt  [2];
  logic signed [EXT_W-1:0] opReg  [2];
  logic                    fracReg;

  assign opWord[0] = inA;
  assign opWord[1] = inB;
  assign opHi[0]   = inHiA;
  assign opHi[1]   = inHiB;
  assign opSign[0] = strobes.signA;
  assign opSign[1] = strobes.signB;

  for (genvar g = 0; g < 2; g++) begin : g_operand
    logic [HALF_W-1:0] half;
    assign half     = opHi[g] ? opWord[g][HALF_W +: HALF_W] : opWord[g][HALF_W-1:0];
    assign opExt[g] = $signed({opSign[g] & half[HALF_W-1], half});

    always_ff @(posedge clk) begin
      if (!rstN) opReg[g] <= '0;
      else if (strobes.s1Load) opReg[g] <= opExt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) fracReg <= 1'b0;
    else if (strobes.s1Load) fracReg <= strobes.frac;
  end

  logic signed [PROD_W-1:0] prodFull;
  logic [WORD_W-1:0]        prodWord;
  localparam logic signed [PROD_W-1:0] FRAC_OVF = PROD_W'(1) <<< (2*HALF_W - 2);
  localparam logic [WORD_W-1:0] POS_MAX = {1'b0, {(WORD_W-1){1'b1}}};

  assign prodFull  = opReg[0] * opReg[1];
  assign satDetect = strobes.s2Load && fracReg && (prodFull == FRAC_OVF);

  always_comb begin
    if (!fracReg)       prodWord = prodFull[WORD_W-1:0];
    else if (satDetect) prodWord = POS_MAX;
    else                prodWord = {prodFull[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outResult <= '0;
      outSat    <= 1'b0;
    end else begin
      outSat <= satDetect;
      if (strobes.s2Load) outResult <= prodWord;
    end
  end
endmodule

// File: rtl/hmul_top.sv
module hmul_top
  import hmul_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          inMode,
  input  logic                inHiA,
  input  logic                inHiB,
  input  logic [2*HALF_W-1:0] inA,
  input  logic [2*HALF_W-1:0] inB,
  input  logic                satClear,
  output logic                outValid,
  output logic [2*HALF_W-1:0] outResult,
  output logic                outSat,
  output logic                satSticky
);
  hmulStrobes_t strobes;
  logic satDetect;

  hmul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .satClear(satClear), .satDetect(satDetect), .strobes(strobes),
    .outValid(outValid), .satSticky(satSticky)
  );

  hmul_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inHiA(inHiA), .inHiB(inHiB),
    .inA(inA), .inB(inB), .satDetect(satDetect), .outResult(outResult),
    .outSat(outSat)
  );
endmodule

// File: rtl/hmul_checker.sv
module hmul_checker #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [1:0]          inMode,
  input logic                satClear,
  input logic                outValid,
  input logic [2*HALF_W-1:0] outResult,
  input logic                outSat,
  input logic                satSticky
);
  logic [1:0] sinceReset;
  always_ff @(posedge clk) begin
    if (!rstN) sinceReset <= 2'd0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2) |-> (outValid == $past(inValid, 2)));

  p_sat_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    outSat |-> (outValid && outResult == {1'b0, {(2*HALF_W-1){1'b1}}}));

  p_sat_only_frac_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2 && outSat) |-> ($past(inMode, 2) == 2'b11));

  p_frac_lsb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd2 && outValid && !outSat && $past(inMode, 2) == 2'b11)
      |-> (outResult[0] == 1'b0));

  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    outSat |-> satSticky);

  p_sticky_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset >= 2'd1 && $fell(satSticky)) |-> $past(satClear));
endmodule

bind hmul_top hmul_checker #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
  .satClear(satClear), .outValid(outValid), .outResult(outResult),
  .outSat(outSat), .satSticky(satSticky)
);

// File: tb/tb_hmul_top.sv
`timescale 1ns/1ps
module tb_hmul_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] inMode = 2'b00;
  logic inHiA = 1'b0, inHiB = 1'b0;
  logic [31:0] inA = '0, inB = '0;
  logic satClear = 1'b0;
  logic outValid, outSat, satSticky;
  logic [31:0] outResult;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hmul_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .inHiA(inHiA), .inHiB(inHiB), .inA(inA), .inB(inB), .satClear(satClear),
    .outValid(outValid), .outResult(outResult), .outSat(outSat),
    .satSticky(satSticky)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Returns {sat, result}
  function automatic logic [32:0] model(logic [31:0] a, logic [31:0] b,
                                        logic ha, logic hb, logic [1:0] m);
    logic [15:0] x, y;
    longint va, vb, p;
    x = ha ? a[31:16] : a[15:0];
    y = hb ? b[31:16] : b[15:0];
    va = (m != 2'b10) ? longint'($signed(x)) : longint'(x);
    vb = (m == 2'b00 || m == 2'b11) ? longint'($signed(y)) : longint'(y);
    p = va * vb;
    if (m == 2'b11) begin
      if (x == 16'h8000 && y == 16'h8000) return {1'b1, 32'h7FFFFFFF};
      p = p * 2;
    end
    return {1'b0, p[31:0]};
  endfunction

  task automatic single(string req, logic [31:0] a, logic [31:0] b,
                        logic ha, logic hb, logic [1:0] m);
    logic [32:0] e;
    e = model(a, b, ha, hb, m);
    @(negedge clk);
    inValid = 1'b1; inA = a; inB = b; inHiA = ha; inHiB = hb; inMode = m;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check(req, 32'(outValid), 32'd1);
    check(req, outResult, e[31:0]);
    check(req, 32'(outSat), 32'(e[32]));
  endtask

  task automatic testReset();
    check("R9 valid", 32'(outValid), 32'd0);
    check("R9 result", outResult, 32'd0);
    check("R9 sat", 32'(outSat), 32'd0);
    check("R9 sticky", 32'(satSticky), 32'd0);
  endtask

  task automatic testModes();
    single("R2 ss lo", 32'h0000FFFD, 32'h00000007, 1'b0, 1'b0, 2'b00);
    single("R2 ss neg", 32'h00008000, 32'h00007FFF, 1'b0, 1'b0, 2'b00);
    single("R1 hiA", 32'h0003FFFF, 32'h00000005, 1'b1, 1'b0, 2'b00);
    single("R1 hiB", 32'h0000AAAA, 32'hFFFE0009, 1'b0, 1'b1, 2'b00);
    single("R1 hiboth", 32'h12340001, 32'h00100002, 1'b1, 1'b1, 2'b10);
    single("R3 su", 32'h0000FFFF, 32'h0000FFFF, 1'b0, 1'b0, 2'b01);
    single("R3 su2", 32'h00000002, 32'h00008000, 1'b0, 1'b0, 2'b01);
    single("R4 uu", 32'h0000FFFF, 32'hFFFF0000, 1'b0, 1'b1, 2'b10);
    single("R6 frac", 32'h00004000, 32'h00004000, 1'b0, 1'b0, 2'b11);
    single("R6 fracneg", 32'h0000C000, 32'h00007FFF, 1'b0, 1'b0, 2'b11);
    single("R6 frac8000x7fff", 32'h80000000, 32'h00007FFF, 1'b1, 1'b0, 2'b11);
  endtask

  task automatic testPipeline();
    logic [31:0] av [6];
    logic [31:0] bv [6];
    logic [1:0]  mv [6];
    logic [32:0] e;
    av = '{32'h00010003, 32'hFFFF0002, 32'h00008000, 32'h7FFF0100, 32'h00000010, 32'h0000FFFF};
    bv = '{32'h00000005, 32'h0003FFFF, 32'h00008000, 32'h00020003, 32'hFFFF0011, 32'h0000FFFF};
    mv = '{2'b00, 2'b01, 2'b11, 2'b10, 2'b00, 2'b11};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        e = model(av[i-2], bv[i-2], (i-2) % 2 == 1, (i-2) % 3 == 0, mv[i-2]);
        check("R5 b2b valid", 32'(outValid), 32'd1);
        check("R5 b2b result", outResult, e[31:0]);
        check("R7 b2b sat", 32'(outSat), 32'(e[32]));
      end
      if (i < 6) begin
        inValid = 1'b1; inA = av[i]; inB = bv[i];
        inHiA = (i % 2 == 1); inHiB = (i % 3 == 0); inMode = mv[i];
      end else inValid = 1'b0;
    end
    @(negedge clk);
    check("R5 valid drops", 32'(outValid), 32'd0);
  endtask

  task automatic testSaturation();
    logic [31:0] held;
    @(negedge clk); satClear = 1'b1;
    @(negedge clk); satClear = 1'b0;
    check("R8 cleared", 32'(satSticky), 32'd0);
    single("R7 sat", 32'h80000000, 32'h00008000, 1'b1, 1'b0, 2'b11);
    check("R8 sticky set", 32'(satSticky), 32'd1);
    @(negedge clk); @(negedge clk);
    check("R8 sticky holds", 32'(satSticky), 32'd1);
    check("R7 sat pulse ends", 32'(outSat), 32'd0);
    satClear = 1'b1;
    @(negedge clk); satClear = 1'b0;
    check("R8 clear", 32'(satSticky), 32'd0);
    // collision: saturation and clear on the same edge
    inValid = 1'b1; inA = 32'h00008000; inB = 32'h00008000;
    inHiA = 1'b0; inHiB = 1'b0; inMode = 2'b11;
    @(negedge clk); inValid = 1'b0; satClear = 1'b1;
    @(negedge clk); satClear = 1'b0;
    check("R8 set wins", 32'(satSticky), 32'd1);
    check("R7 collision sat", 32'(outSat), 32'd1);
    satClear = 1'b1;
    @(negedge clk); satClear = 1'b0;
    // invalid overflow operands ignored
    held = outResult;
    inValid = 1'b0; inA = 32'h00008000; inB = 32'h00008000; inMode = 2'b11;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R10 no valid", 32'(outValid), 32'd0);
    check("R10 no sat", 32'(outSat), 32'd0);
    check("R10 sticky", 32'(satSticky), 32'd0);
    check("R10 result held", outResult, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testModes();
    testPipeline();
    testSaturation();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule